// File: doc/BRIEF.md
# DRAM Refresh Scheduler with CAS-Before-RAS Cycles

This block keeps a DRAM's contents alive by deciding when rows are owed a refresh and then running the refresh cycles itself. A free-running interval counter, sized at elaboration from the clock rate, the retention window and the row count, adds owed rows to a backlog counter. In distributed mode one row is owed every interval, so the rows are spread evenly over the retention window. In burst mode the full row count is owed once per retention window and the rows are refreshed back to back.

Whenever rows are owed, the block raises a bus request to the access controller and holds it until the grant arrives. It then drives the strobes directly. CAS goes low first and stays low, and RAS is pulsed once per owed row, so the DRAM's own internal counter supplies each row address. The request is dropped only once the precharge after the final RAS pulse has run. If the grant is withheld, the owed rows accumulate and are retired in one chain once the bus is granted. A sticky overflow flag is raised if the backlog would go beyond its limit.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, req is 0, ras_n and cas_n are 1 and overflow is 0.
- R2: With burst_mode = 0, one row is owed every INTERVAL = CLK_MHZ*RETENTION_US/ROWS clock cycles. With grant held high, the first RAS fall comes INTERVAL+2+T_CSR rising edges after reset release, and the following falls are exactly INTERVAL cycles apart.
- R3: With burst_mode = 1, ROWS rows are owed once every CLK_MHZ*RETENTION_US cycles. Rows retired within one request are refreshed back to back, with RAS falls T_RAS+T_RP cycles apart.
- R4: req rises when the backlog is non-zero and stays high until grant is seen. While req is 0, grant has no effect, and ras_n and cas_n stay 1.
- R5: CAS-before-RAS ordering: cas_n falls T_CSR cycles before the first RAS fall of a request and stays low until the request ends. RAS never falls while cas_n is high.
- R6: Each RAS low pulse lasts exactly T_RAS cycles. Between pulses of one chain, RAS stays high for exactly T_RP cycles.
- R7: After the last RAS rise of a chain, req and cas_n are released exactly T_RP cycles later. At that point, the number of RAS pulses since reset equals the number of rows owed up to the cycle before the release.
- R8: If a new interval would push the backlog above MAX_OWED, the backlog saturates at MAX_OWED. overflow then goes to 1 on that same edge and stays 1 until reset.
- R9: An interval that ends in the same cycle as a row retirement is neither lost nor double counted: the backlog is incremented and decremented together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_mode | input | 1 | 0 = distributed refresh, 1 = burst refresh |
| grant | input | 1 | Bus grant from the access controller |
| req | output | 1 | Bus request, high while refresh work is pending or running |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| overflow | output | 1 | Sticky flag: the backlog exceeded its limit |

## Verification
Two functions can fall in the same cycle: the interval counter adding an owed row, and the refresh sequencer retiring one at the end of a RAS pulse. With random grant delays of up to 80 cycles, long chains overlap interval boundaries, and these coincidences are provoked repeatedly in both modes. They are judged at every request release, where the bench compares the total number of RAS pulses against the number of owed rows it computes from the elapsed edge count alone. A lost or doubled update shows up there as a count mismatch.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LEAD,
        ST_ACT,
        ST_PRE
    } rf_state_e;

endpackage

// File: rtl/rfsh_tick.sv
module rfsh_tick #(
    parameter int CLK_MHZ      = 250,
    parameter int RETENTION_US = 64000,
    parameter int ROWS         = 4096,
    parameter int OWE_W        = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst,
    output logic [OWE_W-1:0] add_rows
);
    localparam int PERIOD   = CLK_MHZ * RETENTION_US;
    localparam int INTERVAL = PERIOD / ROWS;
    localparam int CNT_W    = $clog2(PERIOD + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_t;

    tick_t            q, d;
    logic [CNT_W-1:0] limit;
    logic             hit;

    always_comb begin
        d        = q;
        limit    = burst ? CNT_W'(PERIOD - 1) : CNT_W'(INTERVAL - 1);
        hit      = (q.cnt >= limit);
        d.cnt    = hit ? '0 : q.cnt + 1'b1;
        add_rows = '0;
        if (hit) add_rows = burst ? OWE_W'(ROWS) : OWE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
    parameter int MAX_OWED = 8192,
    parameter int OWE_W    = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OWE_W-1:0] add_rows,
    input  logic             retire,
    output logic             owed_nz,
    output logic             overflow
);
    typedef struct packed {
        logic [OWE_W-1:0] owed;
        logic             ovf;
    } blog_t;

    blog_t          q, d;
    logic [OWE_W:0] sum;

    always_comb begin
        d   = q;
        // R9: add and retire are merged in one update
        sum = {1'b0, q.owed} + {1'b0, add_rows} - {{OWE_W{1'b0}}, retire};
        if (sum > (OWE_W+1)'(MAX_OWED)) begin
            d.owed = OWE_W'(MAX_OWED);
            d.ovf  = 1'b1;
        end else begin
            d.owed = sum[OWE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign owed_nz  = (q.owed != '0);
    assign overflow = q.ovf;
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
    import dram_refresh_pkg::*;
#(
    parameter int T_CSR = 2,
    parameter int T_RAS = 3,
    parameter int T_RP  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic owed_nz,
    input  logic grant,
    output logic retire,
    output logic req,
    output logic ras_n,
    output logic cas_n
);
    localparam int TMAX  = (T_CSR > T_RAS) ? ((T_CSR > T_RP) ? T_CSR : T_RP)
                                           : ((T_RAS > T_RP) ? T_RAS : T_RP);
    localparam int TMR_W = $clog2(TMAX + 1);

    typedef struct packed {
        rf_state_e        st;
        logic [TMR_W-1:0] tmr;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d      = q;
        retire = 1'b0;
        case (q.st)
            ST_IDLE: if (owed_nz) d.st = ST_WAIT;
            ST_WAIT: if (grant) begin
                d.st  = ST_LEAD;
                d.tmr = TMR_W'(T_CSR - 1);
            end
            ST_LEAD: if (q.tmr == '0) begin
                d.st  = ST_ACT;
                d.tmr = TMR_W'(T_RAS - 1);
            end else begin
                d.tmr = q.tmr - 1'b1;
            end
            ST_ACT: if (q.tmr == '0) begin
                retire = 1'b1;
                d.st   = ST_PRE;
                d.tmr  = TMR_W'(T_RP - 1);
            end else begin
                d.tmr = q.tmr - 1'b1;
            end
            ST_PRE: if (q.tmr == '0) begin
                if (owed_nz) begin
                    d.st  = ST_ACT;
                    d.tmr = TMR_W'(T_RAS - 1);
                end else begin
                    d.st  = ST_IDLE;
                end
            end else begin
                d.tmr = q.tmr - 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st  <= ST_IDLE;
            q.tmr <= '0;
        end else begin
            q <= d;
        end
    end

    assign req   = (q.st != ST_IDLE);
    assign ras_n = (q.st != ST_ACT);
    assign cas_n = !((q.st == ST_LEAD) || (q.st == ST_ACT) || (q.st == ST_PRE));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int CLK_MHZ      = 250,
    parameter int RETENTION_US = 64000,
    parameter int ROWS         = 4096,
    parameter int MAX_OWED     = 2 * ROWS,
    parameter int T_CSR        = 2,
    parameter int T_RAS        = 3,
    parameter int T_RP         = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_mode,
    input  logic grant,
    output logic req,
    output logic ras_n,
    output logic cas_n,
    output logic overflow
);
    localparam int OWE_W = $clog2(MAX_OWED + 1);

    logic [OWE_W-1:0] add_rows;
    logic             retire;
    logic             owed_nz;

    rfsh_tick #(
        .CLK_MHZ(CLK_MHZ), .RETENTION_US(RETENTION_US), .ROWS(ROWS), .OWE_W(OWE_W)
    ) u_tick (
        .clk(clk), .rst_n(rst_n), .burst(burst_mode), .add_rows(add_rows)
    );

    rfsh_backlog #(.MAX_OWED(MAX_OWED), .OWE_W(OWE_W)) u_backlog (
        .clk(clk), .rst_n(rst_n), .add_rows(add_rows), .retire(retire),
        .owed_nz(owed_nz), .overflow(overflow)
    );

    rfsh_seq #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
        .clk(clk), .rst_n(rst_n), .owed_nz(owed_nz), .grant(grant),
        .retire(retire), .req(req), .ras_n(ras_n), .cas_n(cas_n)
    );
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic grant,
    input logic req,
    input logic ras_n,
    input logic cas_n,
    input logic overflow
);
    // R5: RAS only falls after CAS has already been low
    p_cas_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    // R4: with no request pending, both strobes are idle
    p_idle_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (ras_n && cas_n));

    // R4: the request is held until grant
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !grant && ras_n && cas_n) |=> req);

    // R8: the overflow flag is sticky
    p_no_overflow_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R5: CAS is not released while RAS is low
    p_cas_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk i_chk (.*);

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
    localparam int CLK_MHZ = 4, RET_US = 64, ROWS = 8, MAX_OWED = 16;
    localparam int T_CSR = 2, T_RAS = 3, T_RP = 2;
    localparam int L = CLK_MHZ * RET_US / ROWS;
    localparam int PERIOD = CLK_MHZ * RET_US;

    logic clk = 0, rst_n = 0, burst_mode = 0, grant = 0;
    logic req, ras_n, cas_n, overflow;

    dram_refresh_sched #(
        .CLK_MHZ(CLK_MHZ), .RETENTION_US(RET_US), .ROWS(ROWS), .MAX_OWED(MAX_OWED),
        .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)
    ) i_dram_refresh_sched (.*);

    always #2 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0, ecnt = 0;
    int gmode = 0, gdelay = 0;
    bit cnt_chk = 0, dist_chk = 0, chain_chk = 0;
    int pulses = 0, chain = 0, falls = 0, last_fall = 0;
    int cas_run = 0, rlo_run = 0, rhi_run = 0;
    logic p_ras = 1, p_req = 0;

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", r, act, exp, ecnt);
        end
    endtask

    function automatic int exp_rows(input int m, input bit b);
        return ((m - 1) / (b ? PERIOD : L)) * (b ? ROWS : 1);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) ecnt <= 0;
        else        ecnt <= ecnt + 1;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !ras_n) begin
                if (chain == 0) chk(cas_run == T_CSR, "R5", cas_run, T_CSR);
                else            chk(rhi_run == T_RP, "R6", rhi_run, T_RP);
                if (chain_chk && chain > 0)
                    chk(ecnt - last_fall == T_RAS + T_RP, "R3", ecnt - last_fall, T_RAS + T_RP);
                if (dist_chk)
                    chk(ecnt == L + 2 + T_CSR + falls * L, "R2", ecnt, L + 2 + T_CSR + falls * L);
                falls++;
                last_fall = ecnt;
            end
            if (!p_ras && ras_n) begin
                chk(rlo_run == T_RAS, "R6", rlo_run, T_RAS);
                pulses++;
                chain++;
            end
            if (p_req && !req) begin
                chk(rhi_run == T_RP && cas_n, "R7", rhi_run, T_RP);
                if (cnt_chk)
                    chk(pulses == exp_rows(ecnt, burst_mode), burst_mode ? "R3/R7/R9" : "R7/R9",
                        pulses, exp_rows(ecnt, burst_mode));
                chain = 0;
            end
            if (!req && grant) chk(ras_n && cas_n, "R4", {ras_n, cas_n}, 3);
            cas_run = cas_n ? 0 : cas_run + 1;
            rlo_run = ras_n ? 0 : rlo_run + 1;
            rhi_run = !ras_n ? 0 : rhi_run + 1;
            p_ras = ras_n;
            p_req = req;
        end
        case (gmode)
            0: grant <= 1'b1;
            2: grant <= 1'b0;
            default: begin
                if (!req) begin
                    grant  <= 1'($urandom % 2);
                    gdelay  = $urandom % 80;
                end else if (!grant) begin
                    if (gdelay == 0) grant <= 1'b1;
                    else gdelay--;
                end
            end
        endcase
    end

    task automatic do_reset(input bit b, input int gm);
        @(negedge clk);
        rst_n = 0; burst_mode = b; gmode = gm;
        repeat (3) @(negedge clk);
        pulses = 0; chain = 0; falls = 0; last_fall = 0;
        cas_run = 0; rlo_run = 0; rhi_run = 0; p_ras = 1; p_req = 0;
        chk(!req && ras_n && cas_n && !overflow, "R1", {req, ras_n, cas_n, overflow}, 6);
        rst_n = 1;
    endtask

    initial begin
        void'($urandom(32'd1234));
        // distributed, grant tied high
        dist_chk = 1; cnt_chk = 1;
        do_reset(0, 0);
        repeat (6 * L) @(negedge clk);
        dist_chk = 0;
        // burst, grant tied high
        chain_chk = 1;
        do_reset(1, 0);
        repeat (3 * PERIOD) @(negedge clk);
        // grant withheld until overflow
        cnt_chk = 0;
        do_reset(0, 2);
        while (ecnt != 17 * L - 1) @(negedge clk);
        chk(!overflow && req && ras_n, "R8", overflow, 0);
        @(negedge clk);
        chk(overflow == 1, "R8", overflow, 1);
        chk(req && ras_n && cas_n, "R4", {req, ras_n, cas_n}, 7);
        gmode = 0;
        repeat (MAX_OWED * (T_RAS + T_RP) + 20) @(negedge clk);
        chk(overflow == 1, "R8", overflow, 1);
        chk(pulses >= MAX_OWED, "R8", pulses, MAX_OWED);
        // random grant latency, both modes
        cnt_chk = 1;
        do_reset(0, 1);
        repeat (4000) @(negedge clk);
        do_reset(1, 1);
        repeat (6 * PERIOD) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule